// File: doc/BRIEF.md
# SD Command and Response Engine

This block drives the command line of an SD or MMC card. When the engine is idle, a single-cycle start pulse captures a 6-bit command index, a 32-bit argument and an 8-bit attribute word. The engine then shifts a 48-bit command frame out one bit per card-clock cycle, starting with the most significant bit. The frame carries its own CRC7. If the attribute word asks for it, the frame is preceded by an initialisation run of idle clocks with the line held high.

After the end bit the engine releases the line and waits for the card's start bit, bounded by a programmable limit. It then captures either a 48-bit or a 136-bit response and checks its CRC where the format carries one. The engine reports completion, timeout and CRC error in a 16-bit status word. Software-side logic reads the captured response as a stream of 16-bit halfwords through a show-ahead pop port.

The state machine has five states:

- `ST_IDLE`: waits for a start pulse. It goes to `ST_PREAMBLE` when init is requested, otherwise to `ST_SEND`.
- `ST_PREAMBLE`: counts `PREAMBLE_LEN` cycles, then goes to `ST_SEND`.
- `ST_SEND`: shifts out 48 bits. It then goes to `ST_WAIT` when a response is expected, otherwise back to `ST_IDLE`.
- `ST_WAIT`: goes to `ST_RECV` when it samples a start bit, or to `ST_IDLE` when the wait limit expires.
- `ST_RECV`: goes to `ST_IDLE` after the last response bit.

Top module: `sdcmd_engine`

## Requirements
- R1: The command frame is sent most significant bit first, one bit per clock, with `cmd_oe` high throughout. Its layout is start 0, direction 1, the 6-bit index, the 32-bit argument, CRC7 and end bit 1. The CRC7 uses polynomial x^7+x^3+1, starts from zero and covers frame bits 47..8 (index 0, argument 0 gives a last byte of 0x95).
- R2: When attribute bit 7 is set, `cmd_out` stays 1 with `cmd_oe` 1 for exactly `PREAMBLE_LEN` (default 80) cycles before the start bit. When the bit is clear, the start bit is the first bit driven.
- R3: Attribute bits [2:0] select the response: 0 means none, 1 means 48 bits with CRC check, 2 means 136 bits, and 3 means 48 bits without CRC check. Codes 4..7 behave as 0. With no response, completion follows the end bit and the halfword stream stays empty.
- R4: The first clock after the end bit is wait cycle 0, and a start bit is accepted in wait cycles 0 to `rsp_limit`-1 (`rsp_limit` >= 1). Otherwise the engine sets status bit 1 together with completion, and the halfword stream stays empty.
- R5: For code 1 the check covers response bits 46..8; for code 2 it covers bits 127..8. The computed CRC7 is compared with bits 7..1, and a mismatch sets status bit 5. Code 3 never sets bit 5.
- R6: A 48-bit response yields three halfwords. The payload equals (h0<<24)|(h1<<8)|(h2&0xFF), h0[15:8] holds the start, direction and index bits, and h2[15:8] is 0.
- R7: A 136-bit response yields nine halfwords. Word i of the 128 bits 127..0 is {h[2i][7:0], h[2i+1], h[2i+2][15:8]}.
- R8: Status bit 11 sets when the command/response phase ends. All status bits clear when a command is accepted, and status bits other than 11, 5 and 1 are always 0.
- R9: `busy_wait` rises at completion when attribute bit 6 was set and no timeout occurred. It clears when the next command is accepted.
- R10: A start pulse while `eng_busy` is high has no effect on the frame being sent and starts no new command.
- R11: `rf_data` shows the oldest unread halfword and `rf_empty` is high when none remain. A pop on an empty stream has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Active-low reset |
| cmd_start | input | 1 | Start pulse, taken only when idle |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| cmd_attr | input | 8 | [2:0] response code, [6] busy expected, [7] init preamble |
| rsp_limit | input | TO_W | Response wait limit in clocks, held stable during a command |
| cmd_in | input | 1 | Sampled command line from the card |
| cmd_out | output | 1 | Driven command line value |
| cmd_oe | output | 1 | Command line driver enable |
| eng_busy | output | 1 | Engine not idle |
| status | output | 16 | Bit 11 done, bit 5 CRC error, bit 1 timeout |
| busy_wait | output | 1 | Busy indication expected after the last command |
| rf_pop | input | 1 | Advance the halfword stream |
| rf_data | output | 16 | Oldest unread response halfword |
| rf_empty | output | 1 | No unread halfword |

## Verification
The assertions assume that `rsp_limit` is at least 1 and stays fixed while a command runs. They also assume that the card drives `cmd_in` high while idle and sends only a frame of the selected length. The bench card model follows these rules: it changes `cmd_in` on falling edges only, returns the line high after each response, and sweeps the start-bit delay across the limit boundary, including a limit of 1. Start pulses that are meant to be ignored are issued only while the engine is busy, and never in the final frame cycle.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_SEND,
        ST_WAIT,
        ST_RECV
    } sdcmd_state_t;

    typedef enum logic [1:0] {
        RK_NONE,
        RK_SHORT,
        RK_SHORT_NOCRC,
        RK_LONG
    } rsp_kind_t;

    localparam int CMD_BITS  = 48;
    localparam int LONG_BITS = 136;

    function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
        logic fb;
        fb = b ^ c[6];
        return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    endfunction

    function automatic logic [6:0] crc7_of40(input logic [39:0] v);
        logic [6:0] c;
        c = 7'h00;
        for (int i = 39; i >= 0; i--) begin
            c = crc7_step(c, v[i]);
        end
        return c;
    endfunction

    function automatic rsp_kind_t decode_kind(input logic [2:0] code);
        case (code)
            3'd1:    return RK_SHORT;
            3'd2:    return RK_LONG;
            3'd3:    return RK_SHORT_NOCRC;
            default: return RK_NONE;
        endcase
    endfunction

endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       en,
    input  logic       din,
    output logic [6:0] crc
);
    import sdcmd_pkg::*;

    logic [6:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= 7'h00;
        end else if (clear) begin
            crc_q <= 7'h00;
        end else if (en) begin
            crc_q <= crc7_step(crc_q, din);
        end
    end

    assign crc = crc_q;

endmodule

// File: rtl/sdcmd_rsp_fifo.sv
module sdcmd_rsp_fifo #(
    parameter int FRAME_W = 136,
    parameter int HW_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               load,
    input  logic               long_fmt,
    input  logic [FRAME_W-1:0] frame,
    input  logic               pop,
    output logic [HW_W-1:0]    data,
    output logic               empty
);
    localparam int NHW    = (FRAME_W + HW_W - 1) / HW_W;
    localparam int STORE  = NHW * HW_W;
    localparam int PAD    = STORE - FRAME_W;
    localparam int LEFT_W = $clog2(NHW + 1);

    logic [STORE-1:0]  store_q;
    logic [LEFT_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
            left_q  <= '0;
        end else if (clear) begin
            left_q <= '0;
        end else if (load) begin
            if (long_fmt) begin
                store_q <= {frame, {PAD{1'b0}}};
                left_q  <= LEFT_W'(NHW);
            end else begin
                // short frame: upper 32 bits as two halfwords, payload low byte right-aligned
                store_q <= {frame[47:16], 8'h00, frame[15:8], {(STORE-48){1'b0}}};
                left_q  <= LEFT_W'(3);
            end
        end else if (pop && left_q != '0) begin
            store_q <= store_q << HW_W;
            left_q  <= left_q - LEFT_W'(1);
        end
    end

    assign data  = store_q[STORE-1 -: HW_W];
    assign empty = (left_q == '0);

    a_r11_pop_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !load && !clear) |=> empty);

endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine #(
    parameter int TO_W         = 16,
    parameter int PREAMBLE_LEN = 80
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_start,
    input  logic [5:0]      cmd_index,
    input  logic [31:0]     cmd_arg,
    input  logic [7:0]      cmd_attr,
    input  logic [TO_W-1:0] rsp_limit,
    input  logic            cmd_in,
    output logic            cmd_out,
    output logic            cmd_oe,
    output logic            eng_busy,
    output logic [15:0]     status,
    output logic            busy_wait,
    input  logic            rf_pop,
    output logic [15:0]     rf_data,
    output logic            rf_empty
);
    import sdcmd_pkg::*;

    localparam int CNT_MAX = (PREAMBLE_LEN > LONG_BITS) ? PREAMBLE_LEN : LONG_BITS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    sdcmd_state_t          state_q, state_d;
    rsp_kind_t             kind_q;
    logic                  exp_busy_q;
    logic [CNT_W-1:0]      bit_cnt;
    logic [TO_W-1:0]       to_cnt;
    logic [CMD_BITS-1:0]   tx_sr;
    logic [LONG_BITS-1:0]  rx_sr;
    logic [LONG_BITS-1:0]  rx_full;
    logic                  st_done_q, st_to_q, st_crc_q, busy_wait_q;
    logic                  accept, last_rx, to_evt, send_end_none, crc_en, crc_bad;
    logic [CNT_W-1:0]      rx_last_idx;
    logic [6:0]            crc_val;
    logic                  unused_attr_bits;

    assign unused_attr_bits = ^cmd_attr[5:3];

    assign accept        = (state_q == ST_IDLE) && cmd_start;
    assign rx_last_idx   = (kind_q == RK_LONG) ? CNT_W'(LONG_BITS - 1) : CNT_W'(CMD_BITS - 1);
    assign last_rx       = (state_q == ST_RECV) && (bit_cnt == rx_last_idx);
    assign to_evt        = (state_q == ST_WAIT) && cmd_in && (to_cnt == rsp_limit - TO_W'(1));
    assign send_end_none = (state_q == ST_SEND) && (bit_cnt == CNT_W'(CMD_BITS - 1))
                           && (kind_q == RK_NONE);
    assign rx_full       = {rx_sr[LONG_BITS-2:0], cmd_in};

    always_comb begin
        crc_en = 1'b0;
        if (state_q == ST_RECV) begin
            if (kind_q == RK_LONG)
                crc_en = (bit_cnt >= CNT_W'(8)) && (bit_cnt <= CNT_W'(127));
            else
                crc_en = (bit_cnt >= CNT_W'(1)) && (bit_cnt <= CNT_W'(39));
        end
    end

    assign crc_bad = ((kind_q == RK_SHORT) || (kind_q == RK_LONG)) && (crc_val != rx_sr[6:0]);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (cmd_start) state_d = cmd_attr[7] ? ST_PREAMBLE : ST_SEND;
            ST_PREAMBLE: if (bit_cnt == CNT_W'(PREAMBLE_LEN - 1)) state_d = ST_SEND;
            ST_SEND:     if (bit_cnt == CNT_W'(CMD_BITS - 1))
                             state_d = (kind_q == RK_NONE) ? ST_IDLE : ST_WAIT;
            ST_WAIT:     if (!cmd_in) state_d = ST_RECV;
                         else if (to_evt) state_d = ST_IDLE;
            ST_RECV:     if (last_rx) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_oe  = 1'b0;
        cmd_out = 1'b1;
        unique case (state_q)
            ST_PREAMBLE: cmd_oe = 1'b1;
            ST_SEND: begin
                cmd_oe  = 1'b1;
                cmd_out = tx_sr[CMD_BITS-1];
            end
            default: ;
        endcase
    end

    assign eng_busy = (state_q != ST_IDLE);

    // datapath and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            to_cnt     <= '0;
            tx_sr      <= '1;
            rx_sr      <= '0;
            kind_q     <= RK_NONE;
            exp_busy_q <= 1'b0;
        end else begin
            if (state_d != state_q)
                bit_cnt <= (state_d == ST_RECV) ? CNT_W'(1) : '0;
            else if (state_q != ST_IDLE)
                bit_cnt <= bit_cnt + CNT_W'(1);

            to_cnt <= (state_q == ST_WAIT) ? to_cnt + TO_W'(1) : '0;

            if (accept) begin
                tx_sr      <= {2'b01, cmd_index, cmd_arg,
                               crc7_of40({2'b01, cmd_index, cmd_arg}), 1'b1};
                kind_q     <= decode_kind(cmd_attr[2:0]);
                exp_busy_q <= cmd_attr[6];
            end else if (state_q == ST_SEND) begin
                tx_sr <= {tx_sr[CMD_BITS-2:0], 1'b1};
            end

            if (state_q == ST_WAIT)      rx_sr <= '0;
            else if (state_q == ST_RECV) rx_sr <= rx_full;
        end
    end

    // status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_done_q   <= 1'b0;
            st_to_q     <= 1'b0;
            st_crc_q    <= 1'b0;
            busy_wait_q <= 1'b0;
        end else if (accept) begin
            st_done_q   <= 1'b0;
            st_to_q     <= 1'b0;
            st_crc_q    <= 1'b0;
            busy_wait_q <= 1'b0;
        end else begin
            if (send_end_none || to_evt || last_rx) st_done_q <= 1'b1;
            if (to_evt)                             st_to_q   <= 1'b1;
            if (last_rx && crc_bad)                 st_crc_q  <= 1'b1;
            if ((send_end_none || last_rx) && exp_busy_q) busy_wait_q <= 1'b1;
        end
    end

    assign status    = {4'b0, st_done_q, 5'b0, st_crc_q, 3'b0, st_to_q, 1'b0};
    assign busy_wait = busy_wait_q;

    sdcmd_crc7 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q == ST_WAIT),
        .en    (crc_en),
        .din   (cmd_in),
        .crc   (crc_val)
    );

    sdcmd_rsp_fifo #(.FRAME_W(LONG_BITS), .HW_W(16)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .load     (last_rx),
        .long_fmt (kind_q == RK_LONG),
        .frame    (rx_full),
        .pop      (rf_pop),
        .data     (rf_data),
        .empty    (rf_empty)
    );

    a_r8_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[11]) |-> !eng_busy);

    a_r4_timeout_not_crc: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[1] && status[5]));

    a_r4_timeout_empty: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |-> rf_empty);

    a_r1_end_bit_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_oe) |-> $past(cmd_out));

    a_r9_busy_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy_wait |-> status[11]);

endmodule

// File: tb/sim_sdcmd_engine.sv
`timescale 1ns/1ps
module sim_sdcmd_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic [7:0]  cmd_attr = '0;
    logic [15:0] rsp_limit = 16'd8;
    logic        cmd_in = 1'b1;
    logic        cmd_out, cmd_oe, eng_busy, busy_wait, rf_pop, rf_empty;
    logic [15:0] status, rf_data;

    int n_chk = 0;
    int n_fail = 0;

    logic [47:0] got_frame;
    int          got_hi;
    logic        oe_ok;
    logic [15:0] st_first;

    always #2 clk = ~clk;

    sdcmd_engine u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_index(cmd_index),
        .cmd_arg(cmd_arg), .cmd_attr(cmd_attr), .rsp_limit(rsp_limit), .cmd_in(cmd_in),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .eng_busy(eng_busy), .status(status),
        .busy_wait(busy_wait), .rf_pop(rf_pop), .rf_data(rf_data), .rf_empty(rf_empty)
    );

    initial rf_pop = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] crc_ref(input logic [135:0] v, input int hi, input int lo);
        logic [6:0] c = 7'h00;
        logic fb;
        for (int i = hi; i >= lo; i--) begin
            fb = v[i] ^ c[6];
            c = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    function automatic logic [47:0] cmd_frame(input logic [5:0] op, input logic [31:0] arg);
        logic [47:0] f = {2'b01, op, arg, 7'h00, 1'b1};
        f[7:1] = crc_ref({88'h0, f}, 47, 8);
        return f;
    endfunction

    function automatic logic [47:0] short_rsp(input logic [5:0] op, input logic [31:0] arg, input bit good);
        logic [47:0] f = {2'b00, op, arg, 7'h00, 1'b1};
        logic [6:0] c = crc_ref({88'h0, f}, 46, 8);
        f[7:1] = good ? c : (c ^ 7'h05);
        return f;
    endfunction

    function automatic logic [135:0] long_rsp(input logic [119:0] cid, input bit good);
        logic [135:0] f = {2'b00, 6'h3F, cid, 7'h00, 1'b1};
        logic [6:0] c = crc_ref(f, 127, 8);
        f[7:1] = good ? c : (c ^ 7'h11);
        return f;
    endfunction

    task automatic run_cmd(input logic [5:0] op, input logic [31:0] arg, input logic [7:0] attr,
                           input logic [15:0] lim, input int dly, input int rlen,
                           input logic [135:0] rbits, input int glitch);
        int guard;
        @(negedge clk);
        cmd_index = op; cmd_arg = arg; cmd_attr = attr; rsp_limit = lim; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        st_first = status;
        got_hi = 0;
        oe_ok = 1'b1;
        while (cmd_oe && cmd_out && got_hi < 1000) begin
            got_hi++;
            @(negedge clk);
        end
        for (int i = 0; i < 48; i++) begin
            got_frame[47-i] = cmd_out;
            oe_ok = oe_ok & cmd_oe;
            if (i == glitch) begin
                cmd_start = 1'b1; cmd_index = ~op; cmd_arg = ~arg;
            end
            if (i < 47) begin
                @(negedge clk);
                cmd_start = 1'b0; cmd_index = op; cmd_arg = arg;
            end
        end
        if (rlen > 0) begin
            repeat (dly) @(negedge clk);
            for (int i = rlen - 1; i >= 0; i--) begin
                @(negedge clk);
                cmd_in = rbits[i];
            end
            @(negedge clk);
            cmd_in = 1'b1;
        end
        guard = 0;
        while (eng_busy && guard < 500) begin
            guard++;
            @(negedge clk);
        end
    endtask

    task automatic pop_hw(output logic [15:0] hw, input string tag);
        chk(!rf_empty, tag, rf_empty, 0);
        hw = rf_data;
        @(negedge clk); rf_pop = 1'b1;
        @(negedge clk); rf_pop = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] h [0:8];
        logic [47:0] sr;
        logic [135:0] lr;
        logic [31:0] w;
        logic [15:0] expst;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status == 16'h0, "R8 reset status", status, 0);
        chk(!cmd_oe, "R1 reset oe", cmd_oe, 0);
        chk(rf_empty, "R11 reset empty", rf_empty, 1);
        chk(!eng_busy && !busy_wait, "R9 reset busy", {eng_busy, busy_wait}, 0);

        // R1 / R3: frames without response
        for (int k = 0; k < 6; k++) begin
            logic [5:0] op = 6'((k * 11) % 64);
            logic [31:0] arg = 32'h1234_5678 ^ (32'(k) * 32'h9E37_79B9);
            run_cmd(op, arg, 8'h00, 16'd8, 0, 0, '0, -1);
            chk(got_frame == cmd_frame(op, arg), "R1 frame", got_frame, cmd_frame(op, arg));
            chk(oe_ok, "R1 oe during frame", oe_ok, 1);
            chk(got_hi == 0, "R2 no preamble", got_hi, 0);
            chk(status == 16'h0800, "R3 none done", status, 16'h0800);
            chk(rf_empty, "R3 none empty", rf_empty, 1);
        end
        run_cmd(6'd0, 32'd0, 8'h00, 16'd8, 0, 0, '0, -1);
        chk(got_frame[7:0] == 8'h95, "R1 known crc", got_frame[7:0], 8'h95);

        // R2 init preamble
        run_cmd(6'd1, 32'h00FF_8000, 8'h80, 16'd8, 0, 0, '0, -1);
        chk(got_hi == 80, "R2 preamble length", got_hi, 80);
        chk(got_frame == cmd_frame(6'd1, 32'h00FF_8000), "R2 frame after preamble",
            got_frame, cmd_frame(6'd1, 32'h00FF_8000));

        // R3 reserved code 5
        run_cmd(6'd9, 32'hA5A5_0001, 8'h05, 16'd8, 0, 0, '0, -1);
        chk(status == 16'h0800 && rf_empty, "R3 reserved code", status, 16'h0800);

        // R4 timeout sweep
        for (int lim = 1; lim <= 4; lim += 3) begin
            for (int d = 0; d <= lim + 2; d++) begin
                sr = short_rsp(6'd13, 32'hC0DE_0000 + 32'(d), 1'b1);
                run_cmd(6'd13, 32'h0, 8'h01, 16'(lim), d, 48, {88'h0, sr}, -1);
                expst = (d >= lim) ? 16'h0802 : 16'h0800;
                chk(status == expst, "R4 timeout boundary", status, expst);
                chk(rf_empty == (d >= lim), "R4 empty on timeout", rf_empty, (d >= lim));
            end
        end

        // R6 / R5 short responses
        for (int k = 0; k < 5; k++) begin
            logic [31:0] pay = 32'h0100_0001 * 32'(k + 3) ^ 32'hF00F_1234;
            logic [5:0]  op  = 6'(k * 7 + 2);
            sr = short_rsp(op, pay, 1'b1);
            run_cmd(op, 32'h1, 8'h01, 16'd6, k % 3, 48, {88'h0, sr}, -1);
            chk(status == 16'h0800, "R5 good crc", status, 16'h0800);
            for (int j = 0; j < 3; j++) pop_hw(h[j], "R11 not empty");
            w = {h[0][7:0], 24'h0} | {8'h0, h[1], 8'h0} | {24'h0, h[2][7:0]};
            chk(w == pay, "R6 payload", w, pay);
            chk(h[0][15:8] == {2'b00, op}, "R6 header byte", h[0][15:8], {2'b00, op});
            chk(h[2][15:8] == 8'h00, "R6 pad byte", h[2][15:8], 0);
            chk(rf_empty, "R11 drained", rf_empty, 1);
        end
        @(negedge clk); rf_pop = 1'b1;
        @(negedge clk); rf_pop = 1'b0;
        chk(rf_empty && status == 16'h0800, "R11 pop on empty", {rf_empty, status}, {1'b1, 16'h0800});

        sr = short_rsp(6'd17, 32'h1357_9BDF, 1'b0);
        run_cmd(6'd17, 32'h0, 8'h01, 16'd6, 1, 48, {88'h0, sr}, -1);
        chk(status == 16'h0820, "R5 bad crc", status, 16'h0820);

        // R8 clear on accept after error
        run_cmd(6'd2, 32'h0, 8'h00, 16'd6, 0, 0, '0, -1);
        chk(st_first == 16'h0, "R8 clear on accept", st_first, 0);

        // R5 code 3 ignores crc
        sr = {2'b00, 6'h3F, 32'h80FF_8000, 7'h7F, 1'b1};
        run_cmd(6'd41, 32'h0, 8'h03, 16'd6, 2, 48, {88'h0, sr}, -1);
        chk(status == 16'h0800, "R5 code 3 no check", status, 16'h0800);
        for (int j = 0; j < 3; j++) pop_hw(h[j], "R11 not empty");
        w = {h[0][7:0], h[1], h[2][7:0]};
        chk(w == 32'h80FF_8000, "R6 code 3 payload", w, 32'h80FF_8000);

        // R7 long responses
        for (int k = 0; k < 3; k++) begin
            logic [119:0] cid = {4{30'h2AAA_5555 ^ 30'(k * 30'h0123_4567)}};
            lr = long_rsp(cid, 1'b1);
            run_cmd(6'd2, 32'h0, 8'h02, 16'd6, k, 136, lr, -1);
            chk(status == 16'h0800, "R5 long good crc", status, 16'h0800);
            for (int j = 0; j < 9; j++) pop_hw(h[j], "R11 not empty");
            for (int i = 0; i < 4; i++) begin
                w = {h[2*i][7:0], h[2*i+1], h[2*i+2][15:8]};
                chk(w == lr[127-32*i -: 32], "R7 long word", w, lr[127-32*i -: 32]);
            end
            chk(rf_empty, "R7 nine halfwords", rf_empty, 1);
        end
        lr = long_rsp(120'h0123_4567_89AB_CDEF_0011_2233_4455_66, 1'b0);
        run_cmd(6'd9, 32'h0, 8'h02, 16'd6, 0, 136, lr, -1);
        chk(status == 16'h0820, "R5 long bad crc", status, 16'h0820);

        // R9 busy expectation
        sr = short_rsp(6'd7, 32'h0, 1'b1);
        run_cmd(6'd7, 32'h0, 8'h41, 16'd6, 0, 48, {88'h0, sr}, -1);
        chk(busy_wait, "R9 busy set", busy_wait, 1);
        run_cmd(6'd7, 32'h0, 8'h01, 16'd6, 0, 48, {88'h0, sr}, -1);
        chk(!busy_wait, "R9 busy clear", busy_wait, 0);
        run_cmd(6'd7, 32'h0, 8'h41, 16'd2, 5, 48, {88'h0, sr}, -1);
        chk(!busy_wait && status == 16'h0802, "R9 no busy on timeout", busy_wait, 0);

        // R10 start ignored while busy
        run_cmd(6'd24, 32'hDEAD_BEEF, 8'h00, 16'd6, 0, 0, '0, 10);
        chk(got_frame == cmd_frame(6'd24, 32'hDEAD_BEEF), "R10 frame intact",
            got_frame, cmd_frame(6'd24, 32'hDEAD_BEEF));
        repeat (5) @(negedge clk);
        chk(!eng_busy && !cmd_oe, "R10 no new command", {eng_busy, cmd_oe}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule